// File: doc/BRIEF.md
# Valley-Switching Gate Cycle Controller

This block drives the gate of a boost-converter switch, one pulse per switching cycle. The control loop offers an on-time and a minimum off-time for each cycle as a valid/ready command stream. The block accepts one command at the moment a pulse starts and holds the gate high for that many clock cycles. A current-sense comparator can end the pulse early, but only after a leading-edge blanking window has passed. The gate then stays low until the inductor has demagnetized, which the zero-crossing comparator shows once its own blanking window and the commanded off-time have both expired.

Three more rules shape the turn-on. A turn-on never comes sooner than a fixed minimum period after the previous turn-on, which caps the switching frequency. If no zero-crossing arrives, a timeout after the off-time forces a restart. Dropping `enable` pulls the gate low at once. For each completed pulse, a one-cycle status strobe reports how that pulse ended and how it began.

Command stream rules: `cmd_ready` never depends on `cmd_valid`. A command is taken on a clock edge where both are high, and the gate rises on that same edge. The producer must hold `cmd_ton` and `cmd_toff` stable while `cmd_valid` is high and not yet accepted. If the producer withholds `cmd_valid`, turn-on waits for as long as it is withheld. The status outputs have no back-pressure.

Top module: `valley_gate_ctrl`

## Requirements
- R1: While reset is active, and whenever `enable` is low, `gate` and `cmd_ready` are low. `stat_valid` is low out of reset.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `gate` is high in the cycle that follows. `cmd_ready` is high only while `gate` is low. While `cmd_valid` is low, `gate` stays low and `cmd_ready` stays high once a turn-on is due.
- R3: When the block is idle with `enable` high, `cmd_ready` is high at once. The first pulse after `enable` rises starts on the first edge with `cmd_valid` high, without waiting for a zero-crossing.
- R4: Without overcurrent, `gate` stays high for exactly `cmd_ton` cycles of the accepted command. A value of 0 is treated as 1.
- R5: `cs_trip` is ignored while `gate` has been high for `LEB_CYC` cycles or fewer. A high sample of `cs_trip` at the edge where the high time reaches k > `LEB_CYC` ends the pulse, so `gate` is high for k cycles.
- R6: An overcurrent termination does not latch. The next pulse runs its full commanded length when `cs_trip` stays low.
- R7: `zcd_in` is considered only once `gate` has been low for more than `ZCB_CYC` cycles and for at least the accepted `cmd_toff` cycles. A high sample of `zcd_in` at that point, or a sample already latched during the off phase, triggers turn-on at that edge.
- R8: If no qualified zero-crossing occurs, turn-on is triggered when the low time reaches `cmd_toff + TIMEOUT_CYC` cycles.
- R9: Within one enabled run, the interval from one rising edge of `gate` to the next is at least `MIN_PERIOD_CYC` cycles. A trigger that comes earlier is held until that point.
- R10: When `enable` is sampled low, `gate` is low in the next cycle. The cycle in progress is abandoned and reports no status.
- R11: `stat_valid` pulses for one cycle in the first cycle that `gate` is low after a completed pulse. `stat_oc_end` is 1 when that pulse was shorter than its commanded length.
- R12: With `stat_valid`, `stat_timeout_start` is 1 when no qualified zero-crossing had been seen when that pulse started. `stat_cap_delay` is 1 when a trigger was pending but held back by R9. Both flags are 0 for the first pulse after `enable` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low forces the gate off |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready; high when a turn-on may happen now |
| cmd_ton | input | TW | On-time in clock cycles |
| cmd_toff | input | TW | Minimum off-time in clock cycles |
| zcd_in | input | 1 | Zero-crossing comparator, high when the sense is below zero |
| cs_trip | input | 1 | Overcurrent comparator, high when the current exceeds its reference |
| gate | output | 1 | Switch gate drive |
| stat_valid | output | 1 | One-cycle strobe when a pulse ends |
| stat_oc_end | output | 1 | The pulse was ended by overcurrent |
| stat_timeout_start | output | 1 | The pulse was started by timeout |
| stat_cap_delay | output | 1 | The pulse's turn-on was delayed by the period cap |

## Verification
The properties assume that `zcd_in` and `cs_trip` are already synchronous to `clk`, and that command fields do not change while a command waits for acceptance. The window checks also depend on one measurement rule: high and low times are counted in sampled clock cycles, and every run is counted from the last rise of `enable`. The bench changes every input on the falling clock edge. It changes the command words only in the cycle right after the gate rises, so a pending command is never altered. It places comparator events at chosen offsets inside the blanking windows, at their edges and past them, to compare measured pulse widths, gaps and flags against values predicted from these rules.

// File: rtl/vgc_pkg.sv
package vgc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_OFF  = 2'd2
  } vgc_state_e;

  typedef struct packed {
    logic oc_end;
    logic to_start;
    logic cap_delay;
  } vgc_flags_t;

endpackage

// File: rtl/vgc_on_timer.sv
module vgc_on_timer #(
  parameter int TW      = 16,
  parameter int LEB_CYC = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [TW-1:0] ton,
  input  logic          cs_trip,
  output logic          done,
  output logic          oc_hit
);

  logic [TW-1:0] cnt;
  logic [TW-1:0] ton_q;
  logic          len_done;
  logic          blank_over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      ton_q <= TW'(1);
    end else if (load) begin
      cnt   <= TW'(1);
      ton_q <= (ton == '0) ? TW'(1) : ton;
    end else if (run && (cnt != '1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    blank_over = 32'(cnt) > 32'(LEB_CYC);
    len_done   = run && (cnt >= ton_q);
    oc_hit     = run && blank_over && cs_trip && !len_done;
    done       = len_done || oc_hit;
  end

endmodule

// File: rtl/vgc_off_timer.sv
module vgc_off_timer #(
  parameter int TW          = 16,
  parameter int ZCB_CYC     = 40,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          start,
  input  logic          run,
  input  logic [TW-1:0] toff,
  input  logic          zcd_in,
  output logic          zc_fire,
  output logic          to_fire
);

  localparam int OFF_MAX = (2 ** TW) - 1 + TIMEOUT_CYC;
  localparam int CW      = $clog2(OFF_MAX + 2);

  logic [CW-1:0] cnt;
  logic [TW-1:0] toff_q;
  logic          zc_pend;
  logic          armed;

  always_comb begin
    armed   = run && (32'(cnt) >= 32'(toff_q)) && (32'(cnt) > 32'(ZCB_CYC));
    zc_fire = zc_pend || (armed && zcd_in);
    to_fire = run && (32'(cnt) >= (32'(toff_q) + 32'(TIMEOUT_CYC)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      toff_q  <= '0;
      zc_pend <= 1'b0;
    end else begin
      if (load) begin
        toff_q <= toff;
      end
      if (start) begin
        cnt     <= CW'(1);
        zc_pend <= 1'b0;
      end else if (run) begin
        if (32'(cnt) <= 32'(OFF_MAX)) begin
          cnt <= cnt + 1'b1;
        end
        if (armed && zcd_in) begin
          zc_pend <= 1'b1;
        end
      end else begin
        zc_pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vgc_period_guard.sv
module vgc_period_guard #(
  parameter int MIN_PERIOD_CYC = 2858
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ok
);

  localparam int PW = $clog2(MIN_PERIOD_CYC + 1);

  logic [PW-1:0] cnt;

  assign ok = 32'(cnt) >= 32'(MIN_PERIOD_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= PW'(1);
    end else if (!ok) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/valley_gate_ctrl.sv
module valley_gate_ctrl
  import vgc_pkg::*;
#(
  parameter int TW             = 16,
  parameter int LEB_CYC        = 60,
  parameter int ZCB_CYC        = 40,
  parameter int MIN_PERIOD_CYC = 2858,
  parameter int TIMEOUT_CYC    = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [TW-1:0] cmd_ton,
  input  logic [TW-1:0] cmd_toff,
  input  logic          zcd_in,
  input  logic          cs_trip,
  output logic          gate,
  output logic          stat_valid,
  output logic          stat_oc_end,
  output logic          stat_timeout_start,
  output logic          stat_cap_delay
);

  vgc_state_e state;
  vgc_flags_t cur_q;
  vgc_flags_t stat_q;
  logic       cap_seen;
  logic       gate_q;
  logic       on_done;
  logic       oc_hit;
  logic       zc_fire;
  logic       to_fire;
  logic       period_ok;
  logic       trigger;
  logic       launch;
  logic       turn_off;

  assign trigger   = zc_fire || to_fire;
  assign cmd_ready = enable &&
                     ((state == ST_IDLE) || ((state == ST_OFF) && trigger && period_ok));
  assign launch    = cmd_ready && cmd_valid;
  assign turn_off  = enable && (state == ST_ON) && on_done;

  vgc_on_timer #(
    .TW      (TW),
    .LEB_CYC (LEB_CYC)
  ) on_tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .run     (state == ST_ON),
    .ton     (cmd_ton),
    .cs_trip (cs_trip),
    .done    (on_done),
    .oc_hit  (oc_hit)
  );

  vgc_off_timer #(
    .TW          (TW),
    .ZCB_CYC     (ZCB_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) off_tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .start   (turn_off),
    .run     (state == ST_OFF),
    .toff    (cmd_toff),
    .zcd_in  (zcd_in),
    .zc_fire (zc_fire),
    .to_fire (to_fire)
  );

  vgc_period_guard #(
    .MIN_PERIOD_CYC (MIN_PERIOD_CYC)
  ) per_grd_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch),
    .ok    (period_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      gate_q     <= 1'b0;
      stat_valid <= 1'b0;
      stat_q     <= '0;
      cur_q      <= '0;
      cap_seen   <= 1'b0;
    end else begin
      stat_valid <= 1'b0;
      if (!enable) begin
        state    <= ST_IDLE;
        gate_q   <= 1'b0;
        cap_seen <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (launch) begin
              state  <= ST_ON;
              gate_q <= 1'b1;
              cur_q  <= '0;
            end
          end
          ST_ON: begin
            if (on_done) begin
              state            <= ST_OFF;
              gate_q           <= 1'b0;
              stat_valid       <= 1'b1;
              stat_q.oc_end    <= oc_hit;
              stat_q.to_start  <= cur_q.to_start;
              stat_q.cap_delay <= cur_q.cap_delay;
              cap_seen         <= 1'b0;
            end
          end
          ST_OFF: begin
            if (trigger && !period_ok) begin
              cap_seen <= 1'b1;
            end
            if (launch) begin
              state           <= ST_ON;
              gate_q          <= 1'b1;
              cur_q.oc_end    <= 1'b0;
              cur_q.to_start  <= !zc_fire;
              cur_q.cap_delay <= cap_seen;
            end
          end
          default: begin
            state  <= ST_IDLE;
            gate_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign gate               = gate_q;
  assign stat_oc_end        = stat_q.oc_end;
  assign stat_timeout_start = stat_q.to_start;
  assign stat_cap_delay     = stat_q.cap_delay;

endmodule

// File: rtl/valley_gate_chk.sv
module valley_gate_chk #(
  parameter int TW             = 16,
  parameter int LEB_CYC        = 60,
  parameter int ZCB_CYC        = 40,
  parameter int MIN_PERIOD_CYC = 2858
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [TW-1:0] cmd_ton,
  input logic [TW-1:0] cmd_toff,
  input logic          cs_trip,
  input logic          gate,
  input logic          stat_valid,
  input logic          stat_oc_end
);

  logic [31:0]   hi_cnt;
  logic [31:0]   lo_cnt;
  logic [31:0]   per_cnt;
  logic          gate_d;
  logic          armed;
  logic [TW-1:0] ton_lat;
  logic [TW-1:0] toff_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      per_cnt  <= '0;
      gate_d   <= 1'b0;
      armed    <= 1'b0;
      ton_lat  <= TW'(1);
      toff_lat <= '0;
    end else begin
      gate_d  <= gate;
      hi_cnt  <= gate ? hi_cnt + 32'd1 : 32'd0;
      lo_cnt  <= gate ? 32'd0 : lo_cnt + 32'd1;
      per_cnt <= (gate && !gate_d) ? 32'd1 : per_cnt + 32'd1;
      armed   <= enable && (armed || gate);
      if (cmd_valid && cmd_ready) begin
        ton_lat  <= (cmd_ton == '0) ? TW'(1) : cmd_ton;
        toff_lat <= cmd_toff;
      end
    end
  end

  // R1
  idle_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !cmd_ready);

  // R10
  gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate);

  // R2
  ready_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !gate);

  // R2
  accept_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> gate);

  // R4
  ontime_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate) && $past(enable)) |-> (hi_cnt <= 32'(ton_lat)));

  // R5
  leb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate) && $past(enable) && (hi_cnt != 32'(ton_lat)))
      |-> ((hi_cnt > 32'(LEB_CYC)) && $past(cs_trip)));

  // R7
  min_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && armed)
      |-> ((lo_cnt + 32'd1 >= 32'(toff_lat)) && (lo_cnt + 32'd1 > 32'(ZCB_CYC))));

  // R9
  period_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate) && armed) |-> (per_cnt >= 32'(MIN_PERIOD_CYC)));

  // R11
  stat_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ($fell(gate) && $past(enable)));

  // R11
  oc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_oc_end == (hi_cnt != 32'(ton_lat))));

endmodule

bind valley_gate_ctrl valley_gate_chk #(
  .TW             (TW),
  .LEB_CYC        (LEB_CYC),
  .ZCB_CYC        (ZCB_CYC),
  .MIN_PERIOD_CYC (MIN_PERIOD_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_ton     (cmd_ton),
  .cmd_toff    (cmd_toff),
  .cs_trip     (cs_trip),
  .gate        (gate),
  .stat_valid  (stat_valid),
  .stat_oc_end (stat_oc_end)
);

// File: tb/valley_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module valley_gate_ctrl_tb_top;

  localparam int TW   = 8;
  localparam int LEB  = 6;
  localparam int ZCB  = 4;
  localparam int MINP = 40;
  localparam int TMO  = 30;
  localparam int NEVER = 1000000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [TW-1:0] cmd_ton;
  logic [TW-1:0] cmd_toff;
  logic          zcd_in;
  logic          cs_trip;
  logic          gate;
  logic          stat_valid;
  logic          stat_oc_end;
  logic          stat_timeout_start;
  logic          stat_cap_delay;

  int n_checks = 0;
  int n_fail   = 0;
  bit exp_to   = 1'b0;
  bit exp_cap  = 1'b0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  valley_gate_ctrl #(
    .TW(TW), .LEB_CYC(LEB), .ZCB_CYC(ZCB), .MIN_PERIOD_CYC(MINP), .TIMEOUT_CYC(TMO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_ton(cmd_ton), .cmd_toff(cmd_toff),
    .zcd_in(zcd_in), .cs_trip(cs_trip), .gate(gate), .stat_valid(stat_valid),
    .stat_oc_end(stat_oc_end), .stat_timeout_start(stat_timeout_start),
    .stat_cap_delay(stat_cap_delay)
  );

  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction

  function automatic int eff_ton(int ton); return (ton == 0) ? 1 : ton; endfunction

  function automatic int exp_high(int ton, int cs_at);
    if (cs_at < 0) return eff_ton(ton);
    return imin(eff_ton(ton), imax(cs_at + 1, LEB + 1));
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  // Entered at the falling edge where a new rise of gate is first seen.
  task automatic do_cycle(int cs_at, int zc_at, int nton, int ntoff);
    int ton_c  = int'(cmd_ton);
    int toff_c = int'(cmd_toff);
    int hi = 0;
    int lo = 0;
    int eh, kz, kt, ktr, np, el;
    string tag;
    cmd_ton  = TW'(nton);
    cmd_toff = TW'(ntoff);
    while (gate === 1'b1 && hi < 1000) begin
      if (hi == cs_at) cs_trip = 1'b1;
      hi++;
      @(negedge clk);
    end
    cs_trip = 1'b0;
    eh  = exp_high(ton_c, cs_at);
    tag = (eh < eff_ton(ton_c)) ? "R5" : "R4";
    check_eq(tag, "high cycles", hi, eh);
    check_eq("R11", "stat_valid", int'(stat_valid), 1);
    check_eq("R11", "stat_oc_end", int'(stat_oc_end), int'(eh < eff_ton(ton_c)));
    check_eq("R12", "stat_timeout_start", int'(stat_timeout_start), int'(exp_to));
    check_eq("R12", "stat_cap_delay", int'(stat_cap_delay), int'(exp_cap));
    while (gate === 1'b0 && lo < 1000) begin
      if (lo == zc_at) zcd_in = 1'b1;
      lo++;
      @(negedge clk);
    end
    zcd_in = 1'b0;
    kz  = (zc_at < 0) ? NEVER : imax(imax(zc_at + 1, toff_c), ZCB + 1);
    kt  = toff_c + TMO;
    ktr = imin(kz, kt);
    np  = MINP - eh;
    el  = imax(ktr, np);
    if (np > ktr)      tag = "R9";
    else if (kt < kz)  tag = "R8";
    else               tag = "R7";
    check_eq(tag, "low cycles", lo, el);
    exp_to  = (kz > el);
    exp_cap = (np > ktr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
    end
  end

  initial begin
    int hits;
    void'($urandom(32'd2024));
    rst_n = 1'b0; enable = 1'b0; cmd_valid = 1'b0;
    cmd_ton = '0; cmd_toff = '0; zcd_in = 1'b0; cs_trip = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "gate after reset", int'(gate), 0);
    check_eq("R1", "cmd_ready after reset", int'(cmd_ready), 0);
    check_eq("R1", "stat_valid after reset", int'(stat_valid), 0);

    // R1: enable low keeps the gate off even with a command offered
    cmd_ton = 8'd12; cmd_toff = 8'd8; cmd_valid = 1'b1;
    hits = 0;
    repeat (10) begin @(negedge clk); hits += int'(gate) + int'(cmd_ready); end
    check_eq("R1", "gate/ready while disabled", hits, 0);

    // R3: first pulse starts at once
    enable = 1'b1;
    @(negedge clk);
    check_eq("R3", "gate after enable", int'(gate), 1);
    exp_to = 1'b0; exp_cap = 1'b0;

    do_cycle(-1, 3, 20, 0);
    do_cycle(0, 2, 20, 5);     // overcurrent from the first sample
    // R6: after an overcurrent cycle the next runs its full length
    do_cycle(-1, -1, 0, 3);
    do_cycle(-1, 10, 30, 2);   // zero on-time acts as one cycle
    do_cycle(LEB - 1, 0, 25, 12);
    do_cycle(LEB, -1, 25, 20);
    do_cycle(-1, 50, 10, 6);

    for (int i = 0; i < 60; i++) begin
      int cs_at = (($urandom % 3) == 0) ? int'($urandom % 25) : -1;
      int zc_at = (($urandom % 4) != 0) ? int'($urandom % 45) : -1;
      do_cycle(cs_at, zc_at, int'($urandom % 41), int'($urandom % 26));
    end

    // R2: withholding cmd_valid postpones turn-on
    while (gate === 1'b1) @(negedge clk);
    cmd_valid = 1'b0;
    hits = 0;
    repeat (120) begin @(negedge clk); hits += int'(gate); end
    check_eq("R2", "gate while valid low", hits, 0);
    check_eq("R2", "cmd_ready while waiting", int'(cmd_ready), 1);
    cmd_ton = 8'd10; cmd_toff = 8'd3;
    cmd_valid = 1'b1;
    @(negedge clk);
    check_eq("R2", "gate after accept", int'(gate), 1);
    exp_to = 1'b1; exp_cap = 1'b0;
    do_cycle(-1, 5, 10, 3);

    // R10: enable drop abandons the pulse
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check_eq("R10", "gate after enable drop", int'(gate), 0);
    check_eq("R10", "stat_valid after enable drop", int'(stat_valid), 0);
    hits = 0;
    repeat (5) begin @(negedge clk); hits += int'(gate) + int'(stat_valid); end
    check_eq("R10", "activity while disabled", hits, 0);
    enable = 1'b1;
    @(negedge clk);
    check_eq("R3", "gate after re-enable", int'(gate), 1);
    exp_to = 1'b0; exp_cap = 1'b0;
    do_cycle(-1, 4, 10, 3);
    do_cycle(-1, -1, 10, 3);

    done = 1'b1;
    report();
    $finish;
  end

endmodule